// File: doc/BRIEF.md
# SPI Frame Length and Configuration Lock Checker

This block watches a serial control port from the system-clock side and flags two kinds of protocol fault. It brings chip-select, serial clock and serial data into the clock domain, counts serial-clock rising edges while the port is selected, and judges each transaction when chip-select is released. A transaction must carry a whole, non-zero number of bytes. Any movement on the serial clock or data line while a calibration measurement window is open is also a framing fault.

The first byte of each well-formed transaction is taken as the command. Its three top bits select a command class. The block keeps a configuration lock. Once the lock is set, writes to the configuration classes become write errors. An opcode outside the defined set is always a write error. A command that passes every check is reported with a one-cycle execute strobe and its command byte. A status register downstream collects the single-cycle error pulses.

Top module: `spi_frame_lock_checker`

## Requirements
- R1: A transaction whose rising serial-clock count is a non-zero multiple of 8 raises no framing error and has its first byte (sampled MSB first on rising serial-clock edges, serial clock idling low) evaluated as a command.
- R2: A transaction whose rising serial-clock count is not a multiple of 8 produces a framing-error pulse when chip-select is released, and its command is neither executed nor reported as a write error.
- R3: A transaction with no serial-clock edges between chip-select assertion and release produces a framing-error pulse.
- R4: While the calibration window input is high, any edge on the serial clock or serial data line produces a framing-error pulse. If this happens inside a selected transaction, that transaction's command is dropped with no execute strobe, no write error and no lock change.
- R5: The command class is byte bits [7:5]: 000 status read, 001 mask write, 010 mode write, 011 deadtime write, 100 latch clear. Classes 101, 110 and 111 always give a write-error pulse and are never executed.
- R6: While the lock is set, classes 001, 010 and 011 give a write-error pulse and are not executed. Classes 000 and 100 still execute.
- R7: An executed mode write (class 010) with byte bit 0 set raises the lock output. Only reset clears the lock, and a transaction with a framing fault never sets it.
- R8: After reset all outputs are low. The error and execute outputs are single-cycle pulses, and execute and write error are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | Serial clock, idles low |
| spi_cs_n_i | input | 1 | Chip-select, active low |
| spi_mosi_i | input | 1 | Serial data into the device |
| cal_window_i | input | 1 | High while a calibration pulse is being measured |
| frame_err_o | output | 1 | Framing-error pulse |
| write_err_o | output | 1 | Write-error pulse |
| cmd_exec_o | output | 1 | Accepted-command strobe |
| cmd_byte_o | output | 8 | Command byte of the accepted command |
| lock_o | output | 1 | Configuration lock state |

## Verification
Frame lengths of 0, 7, 8, 9, 12 and 16 clocks separate the zero-length rule and the modulo-8 rule from the good case. The 16-clock case also confirms that only the first byte is taken as the opcode. Every command class is sent both before and after the lock is set, so the undefined-opcode rule can be told apart from the lock rule. Line toggles inside and outside a selected frame during the calibration window are both tried. A lock-setting byte is sent in malformed and tainted frames to show that faulty frames leave the lock alone.

// File: rtl/spi_flc_pkg.sv
package spi_flc_pkg;

  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    CLS_STATUS = 3'b000,
    CLS_MASK   = 3'b001,
    CLS_MODE   = 3'b010,
    CLS_DTIME  = 3'b011,
    CLS_CLEAR  = 3'b100
  } cmd_cls_e;

  function automatic logic opc_defined(input logic [OPC_W-1:0] opc);
    return (opc <= CLS_CLEAR);
  endfunction

  function automatic logic opc_restricted(input logic [OPC_W-1:0] opc);
    return (opc == CLS_MASK) || (opc == CLS_MODE) || (opc == CLS_DTIME);
  endfunction

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [STAGES-1:0][W-1:0] chain_q, chain_n;
  logic [W-1:0]             prev_q;

  always_comb begin
    chain_n[0] = d_i;
    for (int i = 1; i < STAGES; i++) begin
      chain_n[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= chain_n;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/spi_frame_counter.sv
module spi_frame_counter #(
  parameter int BYTE_W = 8,
  localparam int MODW  = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_lvl_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              mosi_lvl_i,
  input  logic              mosi_edge_i,
  input  logic              cal_i,
  output logic              frame_ok_o,
  output logic              frame_err_o,
  output logic [BYTE_W-1:0] cmd_byte_o
);

  localparam logic [MODW-1:0] LAST = MODW'(BYTE_W - 1);

  logic [MODW-1:0]   mod_q, mod_n;
  logic              seen_q, seen_n;
  logic              full_q, full_n;
  logic              taint_q, taint_n;
  logic [BYTE_W-1:0] shr_q, shr_n;
  logic              ok_q, ok_n;
  logic              err_q, err_n;
  logic              active, cal_hit, bad_len;

  assign active  = ~cs_n_lvl_i;
  assign cal_hit = cal_i & (sclk_rise_i | sclk_fall_i | mosi_edge_i);
  assign bad_len = ~seen_q | (mod_q != '0);

  always_comb begin
    mod_n   = mod_q;
    seen_n  = seen_q;
    full_n  = full_q;
    taint_n = taint_q;
    shr_n   = shr_q;
    if (cs_fall_i) begin
      mod_n   = '0;
      seen_n  = 1'b0;
      full_n  = 1'b0;
      taint_n = 1'b0;
      shr_n   = '0;
    end else if (active) begin
      if (sclk_rise_i) begin
        seen_n = 1'b1;
        if (!full_q) shr_n = {shr_q[BYTE_W-2:0], mosi_lvl_i};
        if (mod_q == LAST) begin
          mod_n  = '0;
          full_n = 1'b1;
        end else begin
          mod_n = mod_q + 1'b1;
        end
      end
      if (cal_hit) taint_n = 1'b1;
    end
    err_n = cal_hit | (cs_rise_i & bad_len);
    ok_n  = cs_rise_i & ~bad_len & ~taint_q & ~cal_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q   <= '0;
      seen_q  <= 1'b0;
      full_q  <= 1'b0;
      taint_q <= 1'b0;
      shr_q   <= '0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      mod_q   <= mod_n;
      seen_q  <= seen_n;
      full_q  <= full_n;
      taint_q <= taint_n;
      shr_q   <= shr_n;
      ok_q    <= ok_n;
      err_q   <= err_n;
    end
  end

  assign frame_ok_o  = ok_q;
  assign frame_err_o = err_q;
  assign cmd_byte_o  = shr_q;

  a_r1_ok_only_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |-> $past(cs_rise_i));

  a_r4_ok_never_with_cal_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |-> !$past(cal_i && (sclk_rise_i || sclk_fall_i || mosi_edge_i)));

endmodule

// File: rtl/cmd_lock_guard.sv
module cmd_lock_guard
  import spi_flc_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int LOCK_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ok_i,
  input  logic [BYTE_W-1:0] cmd_byte_i,
  output logic              exec_o,
  output logic              werr_o,
  output logic              lock_o,
  output logic [BYTE_W-1:0] cmd_byte_o
);

  logic [OPC_W-1:0]  opc;
  logic              exec_q, exec_n;
  logic              werr_q, werr_n;
  logic              lock_q, lock_n;
  logic [BYTE_W-1:0] cmd_q, cmd_n;

  assign opc = cmd_byte_i[BYTE_W-1 -: OPC_W];

  always_comb begin
    exec_n = 1'b0;
    werr_n = 1'b0;
    lock_n = lock_q;
    cmd_n  = cmd_q;
    if (frame_ok_i) begin
      if (!opc_defined(opc)) begin
        werr_n = 1'b1;
      end else if (opc_restricted(opc) && lock_q) begin
        werr_n = 1'b1;
      end else begin
        exec_n = 1'b1;
        cmd_n  = cmd_byte_i;
        if ((opc == CLS_MODE) && cmd_byte_i[LOCK_BIT]) lock_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_q <= 1'b0;
      werr_q <= 1'b0;
      lock_q <= 1'b0;
      cmd_q  <= '0;
    end else begin
      exec_q <= exec_n;
      werr_q <= werr_n;
      lock_q <= lock_n;
      cmd_q  <= cmd_n;
    end
  end

  assign exec_o     = exec_q;
  assign werr_o     = werr_q;
  assign lock_o     = lock_q;
  assign cmd_byte_o = cmd_q;

  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  a_r8_exec_werr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_q && werr_q));

  a_r8_exec_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    exec_q |-> $past(frame_ok_i));

  a_r5_undefined_never_exec: assert property (@(posedge clk) disable iff (!rst_n)
    exec_q |-> opc_defined(cmd_q[BYTE_W-1 -: OPC_W]));

  a_r6_locked_config_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_q && $past(lock_q)) |-> !opc_restricted(cmd_q[BYTE_W-1 -: OPC_W]));

endmodule

// File: rtl/spi_frame_lock_checker.sv
module spi_frame_lock_checker #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_BIT    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk_i,
  input  logic              spi_cs_n_i,
  input  logic              spi_mosi_i,
  input  logic              cal_window_i,
  output logic              frame_err_o,
  output logic              write_err_o,
  output logic              cmd_exec_o,
  output logic [BYTE_W-1:0] cmd_byte_o,
  output logic              lock_o
);

  localparam int IDX_CS   = 2;
  localparam int IDX_SCLK = 1;
  localparam int IDX_MOSI = 0;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [2:0]        lvl, rise, fall;
  logic              frame_ok;
  logic [BYTE_W-1:0] first_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  spi_edge_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   ({spi_cs_n_i, spi_sclk_i, spi_mosi_i}),
    .lvl_o (lvl),
    .rise_o(rise),
    .fall_o(fall)
  );

  spi_frame_counter #(.BYTE_W(BYTE_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cs_n_lvl_i (lvl[IDX_CS]),
    .cs_fall_i  (fall[IDX_CS]),
    .cs_rise_i  (rise[IDX_CS]),
    .sclk_rise_i(rise[IDX_SCLK]),
    .sclk_fall_i(fall[IDX_SCLK]),
    .mosi_lvl_i (lvl[IDX_MOSI]),
    .mosi_edge_i(rise[IDX_MOSI] | fall[IDX_MOSI]),
    .cal_i      (cal_window_i),
    .frame_ok_o (frame_ok),
    .frame_err_o(frame_err_o),
    .cmd_byte_o (first_byte)
  );

  cmd_lock_guard #(.BYTE_W(BYTE_W), .LOCK_BIT(LOCK_BIT)) u_guard (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .frame_ok_i(frame_ok),
    .cmd_byte_i(first_byte),
    .exec_o    (cmd_exec_o),
    .werr_o    (write_err_o),
    .lock_o    (lock_o),
    .cmd_byte_o(cmd_byte_o)
  );

endmodule

// File: tb/tb_spi_frame_lock_checker.sv
`timescale 1ns/1ps
module tb_spi_frame_lock_checker;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sclk, cs_n, mosi, cal;
  logic       ferr, werr, exec_s, lock;
  logic [7:0] cmd_b;

  int checks = 0, errors = 0;
  int n_ferr = 0, n_werr = 0, n_exec = 0;
  logic prev_exec = 1'b0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  spi_frame_lock_checker dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk_i(sclk), .spi_cs_n_i(cs_n),
    .spi_mosi_i(mosi), .cal_window_i(cal), .frame_err_o(ferr),
    .write_err_o(werr), .cmd_exec_o(exec_s), .cmd_byte_o(cmd_b), .lock_o(lock)
  );

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (ferr)   n_ferr++;
      if (werr)   n_werr++;
      if (exec_s) n_exec++;
      if (exec_s && werr) begin
        errors++;
        $display("FAIL R8 exec and write error together actual 1 expected 0");
      end
      if (exec_s && prev_exec) begin
        errors++;
        $display("FAIL R8 execute strobe wider than one cycle actual 2 expected 1");
      end
      prev_exec = exec_s;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] bits, input int nbits);
    cs_n = 1'b0;
    wclk(4);
    for (int i = 0; i < nbits; i++) begin
      mosi = bits[31-i];
      wclk(4);
      sclk = 1'b1;
      wclk(4);
      sclk = 1'b0;
    end
    wclk(4);
    cs_n = 1'b1;
    wclk(14);
  endtask

  task automatic run_cmd(input logic [31:0] bits, input int nbits, input string req,
                         input int e_ferr, input int e_werr, input int e_exec);
    int f0 = n_ferr, w0 = n_werr, x0 = n_exec;
    xfer(bits, nbits);
    chk(n_ferr - f0 == e_ferr, {req, " framing error count"}, n_ferr - f0, e_ferr);
    chk(n_werr - w0 == e_werr, {req, " write error count"}, n_werr - w0, e_werr);
    chk(n_exec - x0 == e_exec, {req, " execute count"}, n_exec - x0, e_exec);
  endtask

  task automatic t_reset();
    chk(ferr == 0 && werr == 0 && exec_s == 0, "R8 reset pulses", int'(ferr | werr | exec_s), 0);
    chk(lock == 0, "R8 reset lock", lock, 0);
  endtask

  task automatic t_lengths();
    run_cmd(32'h0000_0000, 8,  "R1 8-bit status", 0, 0, 1);
    run_cmd(32'h80FF_0000, 16, "R1 16-bit clear", 0, 0, 1);
    chk(cmd_b == 8'h80, "R1 first byte kept", cmd_b, 8'h80);
    run_cmd(32'h0000_0000, 7,  "R2 7-bit frame", 1, 0, 0);
    run_cmd(32'h0000_0000, 9,  "R2 9-bit frame", 1, 0, 0);
    run_cmd(32'h4100_0000, 12, "R2 R7 12-bit lock byte", 1, 0, 0);
    chk(lock == 0, "R7 lock after bad frame", lock, 0);
  endtask

  task automatic t_zero();
    int f0 = n_ferr, x0 = n_exec;
    cs_n = 1'b0;
    wclk(8);
    cs_n = 1'b1;
    wclk(14);
    chk(n_ferr - f0 == 1, "R3 zero-length frame", n_ferr - f0, 1);
    chk(n_exec - x0 == 0, "R3 zero-length no exec", n_exec - x0, 0);
  endtask

  task automatic t_undefined();
    run_cmd(32'hA000_0000, 8, "R5 opcode 101", 0, 1, 0);
    run_cmd(32'hE000_0000, 8, "R5 opcode 111", 0, 1, 0);
    run_cmd(32'h2000_0000, 8, "R6 mask before lock", 0, 0, 1);
    run_cmd(32'h6000_0000, 8, "R6 deadtime before lock", 0, 0, 1);
    run_cmd(32'h4000_0000, 8, "R7 mode without lock bit", 0, 0, 1);
    chk(lock == 0, "R7 lock stays low", lock, 0);
  endtask

  task automatic t_cal();
    int f0 = n_ferr, w0, x0;
    cal = 1'b1;
    wclk(2);
    mosi = ~mosi; wclk(6);
    mosi = ~mosi; wclk(6);
    cal = 1'b0;
    wclk(8);
    chk(n_ferr - f0 >= 1, "R4 idle toggle in window", n_ferr - f0, 1);
    f0 = n_ferr; w0 = n_werr; x0 = n_exec;
    mosi = 1'b0;
    cs_n = 1'b0;
    wclk(4);
    cal = 1'b1;
    for (int i = 0; i < 8; i++) begin
      mosi = (i == 1 || i == 7);
      wclk(4); sclk = 1'b1; wclk(4); sclk = 1'b0;
    end
    wclk(6);
    cal = 1'b0;
    wclk(4);
    cs_n = 1'b1;
    wclk(14);
    chk(n_ferr - f0 >= 1, "R4 in-frame toggle", n_ferr - f0, 1);
    chk(n_exec - x0 == 0, "R4 tainted frame not executed", n_exec - x0, 0);
    chk(n_werr - w0 == 0, "R4 tainted frame no write error", n_werr - w0, 0);
    chk(lock == 0, "R4 R7 tainted lock byte", lock, 0);
  endtask

  task automatic t_lock();
    run_cmd(32'h4100_0000, 8, "R7 set lock", 0, 0, 1);
    chk(lock == 1, "R7 lock raised", lock, 1);
    run_cmd(32'h2000_0000, 8, "R6 mask after lock", 0, 1, 0);
    run_cmd(32'h4000_0000, 8, "R6 mode after lock", 0, 1, 0);
    run_cmd(32'h6000_0000, 8, "R6 deadtime after lock", 0, 1, 0);
    run_cmd(32'h0000_0000, 8, "R6 status after lock", 0, 0, 1);
    run_cmd(32'h8300_0000, 8, "R6 clear after lock", 0, 0, 1);
    chk(cmd_b == 8'h83, "R6 clear byte", cmd_b, 8'h83);
    run_cmd(32'hC000_0000, 8, "R5 opcode 110 locked", 0, 1, 0);
    run_cmd(32'h0000_0000, 5, "R2 short frame locked", 1, 0, 0);
    chk(lock == 1, "R7 lock persists", lock, 1);
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0; cal = 1'b0;
    wclk(5);
    rst_n = 1'b1;
    wclk(6);
    t_reset();
    t_lengths();
    t_zero();
    t_undefined();
    t_cal();
    t_lock();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule